// File: doc/BRIEF.md
# Sound CPU Port Decoder with Drum Command Mailbox

This block sits on the 8-bit I/O port bus of a sound processor. It turns port writes and reads into per-slot strobes for five programmable sound generator slots: a strobe to select a register, a strobe to write it, and a strobe to read it. It also gives the sound processor a one-byte command path to a separate drum controller. A command byte is written to one group of ports, and a write of any value to another group raises an interrupt line. The interrupt stays raised until the drum side acknowledges it.

Only the low five port bits are decoded, so the whole map repeats every 32 ports. All strobes, the command latch and the interrupt are registered. Each one changes on the clock edge at which the request is sampled. Read data is returned combinationally while the read request is high. Ports that are not mapped return the idle byte. The latched command is also presented decoded: one flag for the "silence everything" code, and a one-hot voice select for the seven percussion voices.

Top module: `snd_io_decode`

## Requirements
- R1: Only port bits 4:0 take part in decoding; ports p, p+0x20, p+0x40 and p+0x60 (and any upper-bit value) behave identically.
- R2: Generator slot k (k = 0..4) occupies ports 4k..4k+3. A write to port 4k pulses `psg_sel_we[k]` (and no other strobe) for the cycle after the clock edge that samples the write.
- R3: A write to port 4k+2 pulses `psg_reg_we[k]` in the same cycle timing, and `psg_wdata` then holds the written byte.
- R4: A read from port 4k+1 pulses `psg_reg_re[k]` after the sampling edge; while `io_rd` is high, `io_rd_data` equals byte k of `psg_rd_bus` (bits 8k+7:8k).
- R5: Offset 3 of each slot, ports 0x1C–0x1F, reads of offsets 0 and 2, and writes of offset 1 produce no strobe; a read of any such port returns 0xFF, and no read is 0xFF-free of this rule.
- R6: A write to any port 0x18–0x1B loads the byte into `drum_cmd`, visible after the sampling edge; writes to any other port leave `drum_cmd` unchanged.
- R7: A write of any value to any port 0x14–0x17 sets `drum_irq` after the sampling edge; writes elsewhere never set it.
- R8: `drum_irq` stays high until a cycle with `drum_ack` high clears it; a new interrupt write in the same cycle as an acknowledge wins, and repeated interrupt writes while pending are not queued (one acknowledge clears them all).
- R9: `drum_stop` is high exactly when `drum_cmd` is 0x00; for command c in 1..7, `drum_voice` is one-hot with bit c-1 set (1 bass drum, 2 low tom, 3 mid tom, 4 high tom, 5 crash cymbal, 6 hi-hat, 7 hum); for c above 7 both are zero.
- R10: During and after reset all strobes are low, `drum_irq` is low, `drum_cmd` is 0x00 and `drum_stop` is high.
- R11: Every strobe lasts one cycle per sampled request, and at most one strobe of all slots is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 8 | I/O port address |
| io_data | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write request, sampled each clock |
| io_rd | input | 1 | I/O read request, sampled each clock |
| io_rd_data | output | 8 | Read data back to the sound processor |
| psg_rd_bus | input | 40 | Read data from the generator slots, byte k for slot k |
| psg_sel_we | output | 5 | Per-slot register select strobe |
| psg_reg_we | output | 5 | Per-slot register write strobe |
| psg_reg_re | output | 5 | Per-slot register read strobe |
| psg_wdata | output | 8 | Byte that goes with the select and write strobes |
| drum_ack | input | 1 | Drum-side interrupt acknowledge |
| drum_cmd | output | 8 | Latched drum command byte |
| drum_irq | output | 1 | Interrupt to the drum controller |
| drum_stop | output | 1 | Latched command is "stop all sound" |
| drum_voice | output | 7 | One-hot percussion voice select |

## Verification
Strobes, `psg_wdata`, `drum_cmd`, `drum_irq` and the decoded voice flags are all one register away from the request. The bench therefore drives a request at a falling edge and samples those results at the next falling edge, which is half a cycle after the edge that captured it. It samples again one cycle later to confirm that the strobes have dropped. `io_rd_data` is combinational, so it is sampled 1 ns after the read is driven and before any clock edge. The acknowledge clears `drum_irq` on the edge that samples it, so the interrupt state is read at the falling edge after the acknowledge pulse.

// File: rtl/snd_io_pkg.sv
package snd_io_pkg;

   // position of a port inside a four-port generator slot
   typedef enum logic [1:0] {
      OFS_SEL   = 2'd0,
      OFS_READ  = 2'd1,
      OFS_WRITE = 2'd2,
      OFS_GAP   = 2'd3
   } slot_ofs_e;

   localparam int SLOT_SPAN = 4;
   localparam int SLOT_OFS_BITS = 2;

endpackage

// File: rtl/snd_port_decode.sv
module snd_port_decode
   import snd_io_pkg::*;
#(
   parameter int DEC_BITS = 5,
   parameter int NUM_PSG  = 5,
   parameter int IRQ_BASE = 20,
   parameter int CMD_BASE = 24
) (
   input  logic [DEC_BITS-1:0] port,
   output logic [NUM_PSG-1:0]  slot_hit,
   output slot_ofs_e           ofs,
   output logic                irq_hit,
   output logic                cmd_hit
);

   localparam int GRP_W = DEC_BITS - SLOT_OFS_BITS;

   logic [GRP_W-1:0] grp;

   assign grp = port[DEC_BITS-1:SLOT_OFS_BITS];
   assign ofs = slot_ofs_e'(port[SLOT_OFS_BITS-1:0]);

   // each slot matches its own four-port group
   for (genvar k = 0; k < NUM_PSG; k++) begin : g_slot
      assign slot_hit[k] = (grp == GRP_W'(k));
   end

   assign irq_hit = (grp == GRP_W'(IRQ_BASE / SLOT_SPAN));
   assign cmd_hit = (grp == GRP_W'(CMD_BASE / SLOT_SPAN));

endmodule

// File: rtl/snd_psg_strobes.sv
module snd_psg_strobes
   import snd_io_pkg::*;
#(
   parameter int NUM_PSG = 5,
   parameter int DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic               io_rd,
   input  logic [NUM_PSG-1:0] slot_hit,
   input  slot_ofs_e          ofs,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_PSG-1:0] sel_we,
   output logic [NUM_PSG-1:0] reg_we,
   output logic [NUM_PSG-1:0] reg_re,
   output logic [DATA_W-1:0]  wdata
);

   for (genvar k = 0; k < NUM_PSG; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sel_we[k] <= 1'b0;
            reg_we[k] <= 1'b0;
            reg_re[k] <= 1'b0;
         end else begin
            sel_we[k] <= io_wr && slot_hit[k] && (ofs == OFS_SEL);
            reg_we[k] <= io_wr && slot_hit[k] && (ofs == OFS_WRITE);
            reg_re[k] <= io_rd && slot_hit[k] && (ofs == OFS_READ);
         end
      end

      // a select strobe only ever follows a sampled write
      assert_sel_after_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
         sel_we[k] |-> $past(io_wr));
      // a register write strobe only ever follows a sampled write
      assert_we_after_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
         reg_we[k] |-> $past(io_wr));
      // a read strobe only ever follows a sampled read
      assert_re_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
         reg_re[k] |-> $past(io_rd));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wdata <= '0;
      else if (io_wr)
         wdata <= wr_data;
   end

   // at most one strobe among all slots in any cycle
   assert_single_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_we, reg_we, reg_re}));

endmodule

// File: rtl/snd_drum_mailbox.sv
module snd_drum_mailbox #(
   parameter int DATA_W     = 8,
   parameter int NUM_VOICES = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  irq_set,
   input  logic                  ack,
   input  logic [DATA_W-1:0]     din,
   output logic [DATA_W-1:0]     cmd,
   output logic                  irq,
   output logic                  stop,
   output logic [NUM_VOICES-1:0] voice
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cmd <= '0;
      else if (load)
         cmd <= din;
   end

   // a new request wins over an acknowledge that arrives in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)
         irq <= 1'b0;
      else if (irq_set)
         irq <= 1'b1;
      else if (ack)
         irq <= 1'b0;
   end

   assign stop = (cmd == '0);

   for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
      assign voice[v] = (cmd == DATA_W'(v + 1));
   end

   assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
   assert_irq_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq_set) |=> !irq);
   assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(irq_set));
   assert_cmd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cmd));
   assert_voice_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stop, voice}));

endmodule

// File: rtl/snd_io_decode.sv
module snd_io_decode
   import snd_io_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int DEC_BITS   = 5,
   parameter int NUM_PSG    = 5,
   parameter int IRQ_BASE   = 20,
   parameter int CMD_BASE   = 24,
   parameter int NUM_VOICES = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         port_addr,
   input  logic [DATA_W-1:0]         io_data,
   input  logic                      io_wr,
   input  logic                      io_rd,
   output logic [DATA_W-1:0]         io_rd_data,
   input  logic [NUM_PSG*DATA_W-1:0] psg_rd_bus,
   output logic [NUM_PSG-1:0]        psg_sel_we,
   output logic [NUM_PSG-1:0]        psg_reg_we,
   output logic [NUM_PSG-1:0]        psg_reg_re,
   output logic [DATA_W-1:0]         psg_wdata,
   input  logic                      drum_ack,
   output logic [DATA_W-1:0]         drum_cmd,
   output logic                      drum_irq,
   output logic                      drum_stop,
   output logic [NUM_VOICES-1:0]     drum_voice
);

   // elaboration-time parameter checks
   if (ADDR_W <= DEC_BITS) begin : g_bad_addr
      $error("port address must be wider than the decoded field");
   end
   if (NUM_PSG * SLOT_SPAN > IRQ_BASE) begin : g_bad_slots
      $error("generator slots overlap the interrupt ports");
   end
   if ((IRQ_BASE % SLOT_SPAN) != 0 || (CMD_BASE % SLOT_SPAN) != 0) begin : g_bad_align
      $error("mailbox port groups must be aligned to four ports");
   end
   if (CMD_BASE + SLOT_SPAN > (1 << DEC_BITS) || IRQ_BASE == CMD_BASE) begin : g_bad_cmd
      $error("mailbox port groups must be distinct and inside the decoded range");
   end
   if (NUM_VOICES >= (1 << DATA_W)) begin : g_bad_voice
      $error("voice count does not fit in the command byte");
   end

   logic [NUM_PSG-1:0] slot_hit;
   slot_ofs_e          ofs;
   logic               irq_hit;
   logic               cmd_hit;
   logic               unused_hi_bits;

   // the upper port bits are aliased away
   assign unused_hi_bits = ^port_addr[ADDR_W-1:DEC_BITS];

   snd_port_decode #(
      .DEC_BITS (DEC_BITS),
      .NUM_PSG  (NUM_PSG),
      .IRQ_BASE (IRQ_BASE),
      .CMD_BASE (CMD_BASE)
   ) u_decode (
      .port     (port_addr[DEC_BITS-1:0]),
      .slot_hit (slot_hit),
      .ofs      (ofs),
      .irq_hit  (irq_hit),
      .cmd_hit  (cmd_hit)
   );

   snd_psg_strobes #(
      .NUM_PSG (NUM_PSG),
      .DATA_W  (DATA_W)
   ) u_strobes (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .io_rd    (io_rd),
      .slot_hit (slot_hit),
      .ofs      (ofs),
      .wr_data  (io_data),
      .sel_we   (psg_sel_we),
      .reg_we   (psg_reg_we),
      .reg_re   (psg_reg_re),
      .wdata    (psg_wdata)
   );

   snd_drum_mailbox #(
      .DATA_W     (DATA_W),
      .NUM_VOICES (NUM_VOICES)
   ) u_mailbox (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (io_wr && cmd_hit),
      .irq_set (io_wr && irq_hit),
      .ack     (drum_ack),
      .din     (io_data),
      .cmd     (drum_cmd),
      .irq     (drum_irq),
      .stop    (drum_stop),
      .voice   (drum_voice)
   );

   // combinational read return; unmapped reads float high
   always_comb begin
      io_rd_data = '1;
      if (io_rd && ofs == OFS_READ) begin
         for (int k = 0; k < NUM_PSG; k++) begin
            if (slot_hit[k])
               io_rd_data = psg_rd_bus[k*DATA_W +: DATA_W];
         end
      end
   end

   // port zero aliases regardless of the upper address bits
   assert_alias_slot0_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && port_addr[DEC_BITS-1:0] == '0) |=> psg_sel_we[0]);
   // a write to an unmapped gap port leaves every strobe low
   assert_gap_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_rd && port_addr[1:0] == 2'd3) |=> (psg_sel_we == '0 && psg_reg_we == '0));

endmodule

// File: tb/snd_io_decode_tb.sv
`timescale 1ns/1ps
module snd_io_decode_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  port_addr = '0;
   logic [7:0]  io_data = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rd_data;
   logic [39:0] psg_rd_bus;
   logic [4:0]  psg_sel_we, psg_reg_we, psg_reg_re;
   logic [7:0]  psg_wdata;
   logic        drum_ack = 1'b0;
   logic [7:0]  drum_cmd;
   logic        drum_irq, drum_stop;
   logic [6:0]  drum_voice;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   snd_io_decode u_dut (
      .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .io_data(io_data),
      .io_wr(io_wr), .io_rd(io_rd), .io_rd_data(io_rd_data),
      .psg_rd_bus(psg_rd_bus), .psg_sel_we(psg_sel_we), .psg_reg_we(psg_reg_we),
      .psg_reg_re(psg_reg_re), .psg_wdata(psg_wdata), .drum_ack(drum_ack),
      .drum_cmd(drum_cmd), .drum_irq(drum_irq), .drum_stop(drum_stop),
      .drum_voice(drum_voice)
   );

   // digits: rd | port | data | kind (0 none,1 sel,2 write,3 read) | slot
   localparam int NV = 21;
   localparam logic [31:0] VEC [NV] = '{
      32'h0_00_11_1_00,  // R2 slot0 select
      32'h0_04_12_1_01,  // R2 slot1 select
      32'h0_08_13_1_02,  // R2 slot2 select
      32'h0_0C_14_1_03,  // R2 slot3 select
      32'h0_10_15_1_04,  // R2 slot4 select
      32'h0_22_5A_2_00,  // R3 R1 slot0 write via alias
      32'h0_46_5B_2_01,  // R3 R1 slot1 write via alias
      32'h0_6A_5C_2_02,  // R3 R1 slot2 write via alias
      32'h0_8E_5D_2_03,  // R3 R1 slot3 write, upper bits set
      32'h0_F2_5E_2_04,  // R3 R1 slot4 write, upper bits set
      32'h1_01_00_3_00,  // R4 slot0 read
      32'h1_25_00_3_01,  // R4 R1 slot1 read via alias
      32'h1_49_00_3_02,  // R4 R1 slot2 read via alias
      32'h1_0D_00_3_03,  // R4 slot3 read
      32'h1_B1_00_3_04,  // R4 R1 slot4 read, upper bits set
      32'h0_03_77_0_00,  // R5 offset 3 write
      32'h1_1F_00_0_00,  // R5 unmapped read
      32'h1_00_00_0_00,  // R5 read of select port
      32'h0_05_66_0_00,  // R5 write of read port
      32'h1_1C_00_0_00,  // R5 unmapped read
      32'h0_1E_99_0_00   // R5 unmapped write
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input logic ack);
      @(negedge clk);
      port_addr = a; io_data = d; io_wr = 1'b1; drum_ack = ack;
      @(negedge clk);
      io_wr = 1'b0; drum_ack = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      drum_ack = 1'b1;
      @(negedge clk);
      drum_ack = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 5; k++) psg_rd_bus[k*8 +: 8] = 8'hA0 + 8'(k);

      // R10 reset state, checked while reset is held and after release
      repeat (3) @(negedge clk);
      chk("R10 strobes in reset", {psg_sel_we, psg_reg_we, psg_reg_re}, 0);
      chk("R10 irq/cmd/stop in reset", {drum_irq, drum_cmd, drum_stop}, {1'b0, 8'h00, 1'b1});
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after release", {drum_irq, drum_cmd, drum_stop, drum_voice},
          {1'b0, 8'h00, 1'b1, 7'h00});

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic       rd;
         logic [7:0] a, d;
         logic [3:0] kind;
         logic [2:0] s;
         logic [7:0] exp_rd;
         string      tg;
         rd = VEC[i][28]; a = VEC[i][27:20]; d = VEC[i][19:12];
         kind = VEC[i][11:8]; s = VEC[i][2:0];
         tg = (kind == 1) ? "R2" : (kind == 2) ? "R3" : (kind == 3) ? "R4" : "R5";
         @(negedge clk);
         port_addr = a; io_data = d; io_wr = !rd; io_rd = rd;
         #1;
         if (rd) begin
            exp_rd = (kind == 3) ? (8'hA0 + 8'(s)) : 8'hFF;
            chk({tg, " R1 read data"}, io_rd_data, exp_rd);
         end
         @(negedge clk);
         io_wr = 1'b0; io_rd = 1'b0;
         chk({tg, " R1 sel strobe"}, psg_sel_we, (kind == 1) ? (5'd1 << s) : 5'd0);
         chk({tg, " R1 write strobe"}, psg_reg_we, (kind == 2) ? (5'd1 << s) : 5'd0);
         chk({tg, " R1 read strobe"}, psg_reg_re, (kind == 3) ? (5'd1 << s) : 5'd0);
         if (kind == 2) chk("R3 wdata", psg_wdata, d);
         chk({tg, " R6 R7 mailbox untouched"}, {drum_irq, drum_cmd}, {1'b0, 8'h00});
         @(negedge clk);
         chk("R11 strobes drop", {psg_sel_we, psg_reg_we, psg_reg_re}, 0);
      end

      // R6 and R9 command latch and voice decode
      do_wr(8'h18, 8'h03, 1'b0);
      chk("R6 cmd load", drum_cmd, 8'h03);
      chk("R9 mid tom", {drum_stop, drum_voice}, {1'b0, 7'b0000100});
      do_wr(8'h7B, 8'h07, 1'b0);
      chk("R6 R1 cmd alias load", drum_cmd, 8'h07);
      chk("R9 hum", {drum_stop, drum_voice}, {1'b0, 7'b1000000});
      do_wr(8'h39, 8'h01, 1'b0);
      chk("R9 bass drum", {drum_stop, drum_voice}, {1'b0, 7'b0000001});
      do_wr(8'h1A, 8'h09, 1'b0);
      chk("R9 out of range", {drum_stop, drum_voice}, {1'b0, 7'b0000000});
      do_wr(8'h19, 8'h00, 1'b0);
      chk("R9 stop", {drum_stop, drum_voice}, {1'b1, 7'b0000000});
      chk("R7 cmd write leaves irq low", drum_irq, 1'b0);

      // R7 and R8 interrupt mailbox
      do_wr(8'h18, 8'h05, 1'b0);
      do_wr(8'h14, 8'h00, 1'b0);
      chk("R7 irq set", drum_irq, 1'b1);
      chk("R6 irq write keeps cmd", drum_cmd, 8'h05);
      do_wr(8'h57, 8'hC3, 1'b0);
      chk("R8 R1 second write keeps irq", drum_irq, 1'b1);
      repeat (3) @(negedge clk);
      chk("R8 irq held", drum_irq, 1'b1);
      pulse_ack();
      chk("R8 ack clears", drum_irq, 1'b0);
      repeat (2) @(negedge clk);
      chk("R8 no queued event", drum_irq, 1'b0);
      do_wr(8'h15, 8'h00, 1'b1);
      chk("R8 set wins over ack", drum_irq, 1'b1);
      pulse_ack();
      chk("R8 ack after collision", drum_irq, 1'b0);
      pulse_ack();
      chk("R8 idle ack harmless", drum_irq, 1'b0);

      // R11 back-to-back writes give one pulse per sampled request
      @(negedge clk);
      port_addr = 8'h04; io_wr = 1'b1;
      @(negedge clk);
      chk("R11 first pulse", psg_sel_we, 5'b00010);
      port_addr = 8'h0A;
      @(negedge clk);
      io_wr = 1'b0;
      chk("R11 second request other slot", {psg_sel_we, psg_reg_we}, {5'b00000, 5'b00100});
      @(negedge clk);
      chk("R11 all low", {psg_sel_we, psg_reg_we, psg_reg_re}, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule